// File: doc/BRIEF.md
# Local Bus Interrupt Controller

This block gathers sixteen level-sensitive interrupt request lines from local peripherals into a source register. A writable enable mask gates that register. One combined interrupt line goes to the processor and is high while any enabled source is pending. Software sees two 16-bit registers on a small register bus. The vector register reads back a code that identifies the pending enabled source with the highest priority. The enable-mask register can be read and written.

The bus accepts byte, halfword and word accesses. A byte write to the mask changes only the addressed byte and keeps the other byte of the current mask. A word access is handled as two halfword accesses: the low half goes to the given address and the high half goes to that address plus two. Read data comes back registered, one cycle after the request.

Top module: `irqc_local_bus`

## Requirements
- R1: Each request input is level-sensitive. Source bit n copies `irq_req_i[n]` at every rising clock edge, so it sets while the line is high and clears when the line drops.
- R2: `irq_o` is high exactly when (source AND mask) is nonzero. It follows a change of a request line or of the mask at the same clock edge that updates the source or mask register.
- R3: A read of the vector register (halfword offset 0) returns ((n+1) << 2) in bits [15:0], where n is the selected pending enabled line. It returns 0 when no enabled line is pending.
- R4: After reset the mask is 0x0010, so line 4 is enabled. The source register, `irq_o` and `rd_valid_o` are 0.
- R5: When several enabled lines are pending, the vector names the lowest-numbered one.
- R6: The mask register sits at offset 2. A byte write (size code 0) with address bit 0 = 0 replaces mask bits [7:0], and with address bit 0 = 1 it replaces bits [15:8]. The new byte comes from `acc_wdata_i[7:0]` and the other byte keeps its value. A halfword write (size code 1) replaces the whole mask from `acc_wdata_i[15:0]`.
- R7: A word access (size code 2) acts as a halfword access at the given offset using data bits [15:0], plus a halfword access at offset+2 using data bits [31:16]. Address bit 0 is ignored for halfword and word accesses.
- R8: Any offset other than 0 and 2 reads as zero and ignores writes. A write to the vector register has no effect.
- R9: A read returns data on `rd_data_o` with `rd_valid_o` high in the cycle after the request. Byte reads return the addressed byte in bits [7:0] and halfword reads return bits [15:0], with the upper bits zero in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | 16 | Level-sensitive request lines |
| acc_valid_i | input | 1 | Bus access request |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| acc_addr_i | input | ADDR_W | Byte offset within the block |
| acc_wdata_i | input | 32 | Write data, right-aligned |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |
| irq_o | output | 1 | Combined interrupt to the processor |

## Verification
The assertions check on every clock the properties that do not depend on the scenario:
- the combined output always equals the OR of source AND mask;
- the source register tracks the request lines one cycle behind;
- the encoder always selects a pending line that has no pending line below it;
- the mask never moves without a write;
- the read-valid strobe matches the previous cycle's read request.

Only the bench scenarios can show the actual vector codes, the mask reset value, the byte merge, the splitting of word accesses, and that undefined offsets stay silent.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int REG_W  = 16;
  localparam int DATA_W = 32;
  localparam int IDX_W  = $clog2(REG_W);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  // halfword slot numbers (byte offset / 2)
  localparam int SLOT_VEC  = 0;
  localparam int SLOT_MASK = 1;
endpackage

// File: rtl/irqc_src_sync.sv
module irqc_src_sync
  import irqc_pkg::*;
#(
  parameter int N = REG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] src_o
);
  always_ff @(posedge clk) begin
    if (rst) src_o <= '0;
    else     src_o <= req_i;
  end

  // R1: source tracks the request level one edge later
  p_src_follow_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (src_o == $past(req_i)));
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc
  import irqc_pkg::*;
#(
  parameter int N  = REG_W,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  pend_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  logic [N:0]   seen;
  logic [N-1:0] hit;

  assign seen[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_chain
    assign seen[g+1] = seen[g] | pend_i[g];
    assign hit[g]    = pend_i[g] & ~seen[g];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i]) idx_o = idx_o | IW'(i);
    end
  end

  assign any_o = seen[N];

  // R5: the chosen line is pending and nothing below it is
  p_lowest_wins_r5: assert property (@(posedge clk) disable iff (rst)
    any_o |-> (pend_i[idx_o] && ((pend_i & ((N'(1) << idx_o) - N'(1))) == '0)));
  // R3: no selection reported when nothing is pending
  p_none_pending_r3: assert property (@(posedge clk) disable iff (rst)
    (pend_i == '0) |-> !any_o);
  p_hit_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));
endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
  import irqc_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [15:0] MASK_RST = 16'h0010,
  localparam int         SLOT_W   = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [1:0]        acc_size_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  input  logic [REG_W-1:0]  vec_i,
  output logic [REG_W-1:0]  mask_o,
  output logic [REG_W-1:0]  mask_next_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [SLOT_W-1:0] lo_slot, hi_slot;
  logic              is_word, is_byte, wr;
  logic [REG_W-1:0]  lo_wval, rd_lo, rd_hi;
  logic [DATA_W-1:0] rd_next;

  assign lo_slot = acc_addr_i[ADDR_W-1:1];
  assign hi_slot = lo_slot + SLOT_W'(1);
  assign is_word = (acc_size_i == SZ_WORD);
  assign is_byte = (acc_size_i == SZ_BYTE);
  assign wr      = acc_valid_i && acc_write_i;

  function automatic logic [REG_W-1:0] slot_read(input logic [SLOT_W-1:0] s,
                                                 input logic [REG_W-1:0] v,
                                                 input logic [REG_W-1:0] m);
    if (s == SLOT_W'(SLOT_VEC))       return v;
    else if (s == SLOT_W'(SLOT_MASK)) return m;
    else                              return '0;
  endfunction

  // byte lane merge into the current mask
  always_comb begin
    if (is_byte) begin
      if (acc_addr_i[0]) lo_wval = {acc_wdata_i[7:0], mask_o[7:0]};
      else               lo_wval = {mask_o[15:8], acc_wdata_i[7:0]};
    end else begin
      lo_wval = acc_wdata_i[15:0];
    end
  end

  always_comb begin
    mask_next_o = mask_o;
    if (wr) begin
      if (lo_slot == SLOT_W'(SLOT_MASK))
        mask_next_o = lo_wval;
      else if (is_word && hi_slot == SLOT_W'(SLOT_MASK))
        mask_next_o = acc_wdata_i[31:16];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mask_o <= MASK_RST;
    else     mask_o <= mask_next_o;
  end

  assign rd_lo = slot_read(lo_slot, vec_i, mask_o);
  assign rd_hi = slot_read(hi_slot, vec_i, mask_o);

  always_comb begin
    case (acc_size_i)
      SZ_BYTE: rd_next = {24'd0, acc_addr_i[0] ? rd_lo[15:8] : rd_lo[7:0]};
      SZ_HALF: rd_next = {16'd0, rd_lo};
      SZ_WORD: rd_next = {rd_hi, rd_lo};
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= acc_valid_i && !acc_write_i;
      if (acc_valid_i && !acc_write_i) rd_data_o <= rd_next;
    end
  end

  // R6/R8: mask moves only on a write
  p_mask_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr)) |-> $stable(mask_o));
  // R9: read strobe one cycle after a read request
  p_rd_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rd_valid_o == $past(acc_valid_i && !acc_write_i)));
  // R4: reset value of the mask
  p_mask_reset_r4: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_o == MASK_RST));
endmodule

// File: rtl/irqc_local_bus.sv
module irqc_local_bus
  import irqc_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [15:0] MASK_RST = 16'h0010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       irq_req_i,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [1:0]        acc_size_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [31:0]       acc_wdata_i,
  output logic              rd_valid_o,
  output logic [31:0]       rd_data_o,
  output logic              irq_o
);
  logic [REG_W-1:0] src_q, mask_q, mask_next, pend, vec;
  logic             any_pend;
  logic [IDX_W-1:0] sel_idx;

  irqc_src_sync #(.N(REG_W)) u_src (
    .clk(clk), .rst(rst), .req_i(irq_req_i), .src_o(src_q)
  );

  assign pend = src_q & mask_q;

  irqc_prio_enc #(.N(REG_W)) u_enc (
    .clk(clk), .rst(rst), .pend_i(pend), .any_o(any_pend), .idx_o(sel_idx)
  );

  assign vec = any_pend ? ((REG_W'(sel_idx) + REG_W'(1)) << 2) : '0;

  irqc_regfile #(.ADDR_W(ADDR_W), .MASK_RST(MASK_RST)) u_regs (
    .clk(clk), .rst(rst),
    .acc_valid_i(acc_valid_i), .acc_write_i(acc_write_i),
    .acc_size_i(acc_size_i), .acc_addr_i(acc_addr_i),
    .acc_wdata_i(acc_wdata_i), .vec_i(vec),
    .mask_o(mask_q), .mask_next_o(mask_next),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  // registered combined output, aligned with the source and mask registers
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(irq_req_i & mask_next);
  end

  // R2: output agrees with the gated source register on every cycle
  p_irq_level_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_o == (pend != '0)));
  // R4: quiet after reset
  p_irq_reset_r4: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_o && src_q == '0));
endmodule

// File: tb/tb_irqc_local_bus.sv
module tb_irqc_local_bus;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] irq_req_i;
  logic        acc_valid_i, acc_write_i;
  logic [1:0]  acc_size_i;
  logic [7:0]  acc_addr_i;
  logic [31:0] acc_wdata_i;
  logic        rd_valid_o;
  logic [31:0] rd_data_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irqc_local_bus dut (.*);

  // entries: {request, mask, expected vector}
  localparam int NV = 9;
  localparam logic [NV-1:0][47:0] VECS = {
    {16'h0001, 16'hFFFF, 16'h0004},
    {16'h8000, 16'hFFFF, 16'h0040},
    {16'h8010, 16'h8000, 16'h0040},
    {16'h8010, 16'h0010, 16'h0014},
    {16'h00F0, 16'h00C0, 16'h001C},
    {16'h1234, 16'h0000, 16'h0000},
    {16'h0000, 16'hFFFF, 16'h0000},
    {16'hFFFF, 16'hFFFE, 16'h0008},
    {16'h0A00, 16'h0F00, 16'h0028}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    acc_valid_i = 1; acc_write_i = 1; acc_addr_i = a; acc_size_i = sz; acc_wdata_i = d;
    @(negedge clk);
    acc_valid_i = 0; acc_write_i = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    acc_valid_i = 1; acc_write_i = 0; acc_addr_i = a; acc_size_i = sz;
    @(negedge clk);
    acc_valid_i = 0;
    check("R9 rd_valid", {31'd0, rd_valid_o}, 32'd1);
    d = rd_data_o;
  endtask

  task automatic set_req(input logic [15:0] r);
    @(negedge clk);
    irq_req_i = r;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst = 1; irq_req_i = '0; acc_valid_i = 0; acc_write_i = 0;
    acc_size_i = 0; acc_addr_i = 0; acc_wdata_i = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R4 reset state
    check("R4 irq_o after reset", {31'd0, irq_o}, 0);
    check("R4 rd_valid after reset", {31'd0, rd_valid_o}, 0);
    bus_rd(8'h02, 2'd1, d); check("R4 mask reset", d, 32'h0010);
    bus_rd(8'h00, 2'd1, d); check("R3 vector idle", d, 32'h0000);

    // R4: line 4 enabled out of reset; R1 level follow
    set_req(16'h0010);
    check("R4 line4 enabled irq", {31'd0, irq_o}, 1);
    bus_rd(8'h00, 2'd1, d); check("R3 vector line4", d, 32'h0014);
    set_req(16'h0008);
    check("R1 masked line no irq", {31'd0, irq_o}, 0);
    set_req(16'h0000);
    check("R1 level cleared", {31'd0, irq_o}, 0);

    // table walk: R2 R3 R5
    for (int i = NV - 1; i >= 0; i--) begin
      bus_wr(8'h02, 2'd1, {16'd0, VECS[i][31:16]});
      set_req(VECS[i][47:32]);
      check("R2 table irq", {31'd0, irq_o}, {31'd0, (VECS[i][15:0] != 0)});
      bus_rd(8'h00, 2'd1, d);
      check("R3/R5 table vector", d, {16'd0, VECS[i][15:0]});
    end

    // R2: mask change drops output on the write edge
    bus_wr(8'h02, 2'd1, 32'h0000_0200);
    set_req(16'h0200);
    check("R2 irq before mask clear", {31'd0, irq_o}, 1);
    @(negedge clk);
    acc_valid_i = 1; acc_write_i = 1; acc_addr_i = 8'h02; acc_size_i = 2'd1; acc_wdata_i = 0;
    @(negedge clk);
    acc_valid_i = 0; acc_write_i = 0;
    check("R2 irq after mask clear", {31'd0, irq_o}, 0);

    // R6 byte merge
    bus_wr(8'h02, 2'd1, 32'h0000_1234);
    bus_wr(8'h03, 2'd0, 32'hFFFF_FFAB);
    bus_rd(8'h02, 2'd1, d); check("R6 high byte write", d, 32'h0000_AB34);
    bus_wr(8'h02, 2'd0, 32'h0000_00CD);
    bus_rd(8'h02, 2'd1, d); check("R6 low byte write", d, 32'h0000_ABCD);
    bus_rd(8'h03, 2'd0, d); check("R9 byte read high", d, 32'h0000_00AB);

    // R7 word access split
    set_req(16'h0001);
    bus_rd(8'h00, 2'd2, d); check("R7 word read", d, 32'hABCD_0004);
    bus_wr(8'h00, 2'd2, 32'h5A5A_FFFF);
    bus_rd(8'h02, 2'd1, d); check("R7 word write high half to mask", d, 32'h0000_5A5A);
    bus_rd(8'h02, 2'd2, d); check("R7/R8 word read at 2", d, 32'h0000_5A5A);

    // R8 undefined offsets and vector write ignored
    bus_wr(8'h04, 2'd1, 32'h0000_FFFF);
    bus_wr(8'h00, 2'd1, 32'h0000_FFFF);
    bus_rd(8'h02, 2'd1, d); check("R8 mask untouched", d, 32'h0000_5A5A);
    bus_rd(8'h04, 2'd1, d); check("R8 undefined reads zero", d, 32'h0);
    bus_rd(8'h00, 2'd1, d); check("R8 vector unchanged", d, 32'h0000_0000);
    check("R2 irq with mask 5A5A req 1", {31'd0, irq_o}, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule